// File: doc/BRIEF.md
# Crossbar Cross-Point Programming Sequencer

This block programs one output column of a sectioned, matrix-style crossbar. The crossbar's output buses also serve as write bit lines for the cross-point cells. A requester presents a routing request naming an output channel, a source input and a configuration slot. When the block takes the request, it drives the column over two registered cycles.

The first cycle erases the column. Every section wordline goes high while the column's bus carries zeros, so every cross-point cell of that column in the selected slot is written low. The second cycle allocates the column. One wordline, for the section that holds the source, goes high while a one-hot code marks the source's position inside that section.

A channel that is to be left unconnected gets only the erase cycle. A request whose source or slot lies outside the array is refused with an error pulse and touches nothing. Slots that are already programmed are reused without passing through this block. Programming one slot costs two cycles per channel, or one cycle for a channel left unconnected.

Top module: `xbar_prog_seq`

## Requirements
- R1: A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while no sequence is running, and a `req_valid` held during a running sequence starts nothing.
- R2: In the cycle after a request is taken, the block drives the erase cycle: `prog_active`=1, all bits of `prog_wl` set, `prog_bus` all zero, and `prog_col` with only bit `req_chan` set.
- R3: In the cycle after the erase, the block drives the allocate cycle. `prog_wl` has only bit `src / BUS_W` set and `prog_bus` has only bit `src % BUS_W` set, taken from the low bits of the source index. With 16-bit buses, source 43 sets wordline bit 2 and bus bit 11 (16'h0800).
- R4: A request with `req_unused`=1 gets the erase cycle only. No allocate cycle follows, and `req_src` is neither checked nor used.
- R5: `done` is high for exactly one cycle, in the cycle right after the last programming cycle of a sequence. `req_ready` is high again in that same cycle.
- R6: A request with a source index of `NUM_IN` or more (when `req_unused`=0), or with a slot of `NUM_SLOTS` or more, is refused. `err` goes high for one cycle in the cycle after the request. During that cycle no wordline, column or `prog_active` is driven, `done` stays low, and `req_ready` stays high.
- R7: No column is enabled while no sequence is running, so no column is ever held away from data traffic outside its own programming cycles. During a sequence exactly one column bit is set.
- R8: After reset, `req_ready`=1 and `prog_active`, `prog_col`, `prog_wl`, `prog_bus`, `prog_slot`, `done` and `err` are all zero.
- R9: `prog_slot` carries the requested slot, unchanged, through both programming cycles of a sequence, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | $clog2(NUM_OUT) | Output channel (column) to program |
| req_src | input | $clog2(NUM_IN)+1 | Source input index |
| req_slot | input | $clog2(NUM_SLOTS) | Configuration slot to write |
| req_unused | input | 1 | Leave the channel unconnected |
| prog_active | output | 1 | A programming cycle is on the array |
| prog_col | output | NUM_OUT | One-hot column whose bus is driven |
| prog_wl | output | NUM_IN/BUS_W | Section wordlines |
| prog_bus | output | BUS_W | Code driven on the selected column bus |
| prog_slot | output | $clog2(NUM_SLOTS) | Slot select for the cells being written |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| err | output | 1 | Request refused (one-cycle pulse) |

## Verification
The bench uses the worked example, source 43, to fix the section/bit split. It uses the first and last sources, 0 and 127, on the first and last channels to expose off-by-one errors in the slicing and in the column decode.

An unused-channel request shows whether the allocate cycle is really skipped. Sources 128 and 255 and slots 6 and 7 separate a correct range check from one that wraps.

A `req_valid` held through a busy sequence with a changed payload shows whether the handshake ignores it. Requests sent back to back across different slots show that the slot select follows each request and that no state from the previous sequence leaks into the next.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_ALLOC = 2'd2
  } seq_state_t;
endpackage

// File: rtl/xbp_src_decode.sv
// Splits a source index into a section (wordline) and a bit within the
// section bus, and range-checks source and slot.
module xbp_src_decode #(
  parameter int NUM_IN    = 128,
  parameter int BUS_W     = 16,
  parameter int NUM_SLOTS = 6,
  parameter int SRC_W     = $clog2(NUM_IN) + 1,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [SRC_W-1:0]         src,
  input  logic [SLOT_W-1:0]        slot,
  input  logic                     unused,
  output logic [NUM_IN/BUS_W-1:0]  sec_oh,
  output logic [BUS_W-1:0]         bit_oh,
  output logic                     req_ok
);
  localparam int NUM_SEC = NUM_IN / BUS_W;
  localparam int BIT_W   = $clog2(BUS_W);
  localparam int SEC_W   = $clog2(NUM_SEC);
  localparam int SEC_HI  = BIT_W + SEC_W - 1;

  logic src_ok, slot_ok;

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    assign sec_oh[g] = (src[SEC_HI:BIT_W] == SEC_W'(g));
  end

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    assign bit_oh[b] = (src[BIT_W-1:0] == BIT_W'(b));
  end

  always_comb begin
    src_ok  = (int'(src) < NUM_IN);
    slot_ok = (int'(slot) < NUM_SLOTS);
    req_ok  = slot_ok && (unused || src_ok);
  end
endmodule

// File: rtl/xbp_col_decode.sv
// Channel index to one-hot column enable.
module xbp_col_decode #(
  parameter int NUM_OUT = 16,
  parameter int CH_W    = $clog2(NUM_OUT)
) (
  input  logic [CH_W-1:0]    chan,
  output logic [NUM_OUT-1:0] col_oh
);
  for (genvar c = 0; c < NUM_OUT; c++) begin : g_col
    assign col_oh[c] = (chan == CH_W'(c));
  end
endmodule

// File: rtl/xbp_seq.sv
// Erase-then-allocate sequencer with registered array-side outputs.
module xbp_seq
  import xbp_pkg::*;
#(
  parameter int NUM_SEC = 8,
  parameter int BUS_W   = 16,
  parameter int NUM_OUT = 16,
  parameter int SLOT_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_unused,
  input  logic               req_ok,
  input  logic [NUM_SEC-1:0] sec_oh,
  input  logic [BUS_W-1:0]   bit_oh,
  input  logic [NUM_OUT-1:0] col_oh,
  input  logic [SLOT_W-1:0]  slot_in,
  output logic               req_ready,
  output logic               prog_active,
  output logic [NUM_OUT-1:0] prog_col,
  output logic [NUM_SEC-1:0] prog_wl,
  output logic [BUS_W-1:0]   prog_bus,
  output logic [SLOT_W-1:0]  prog_slot,
  output logic               done,
  output logic               err
);
  seq_state_t         state;
  logic [NUM_SEC-1:0] hold_sec;
  logic [BUS_W-1:0]   hold_bit;
  logic               hold_unused;

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      hold_sec    <= '0;
      hold_bit    <= '0;
      hold_unused <= 1'b0;
      prog_active <= 1'b0;
      prog_col    <= '0;
      prog_wl     <= '0;
      prog_bus    <= '0;
      prog_slot   <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!req_ok) begin
              err <= 1'b1;
            end else begin
              state       <= ST_ERASE;
              hold_sec    <= sec_oh;
              hold_bit    <= bit_oh;
              hold_unused <= req_unused;
              prog_active <= 1'b1;
              prog_col    <= col_oh;
              prog_wl     <= '1;
              prog_bus    <= '0;
              prog_slot   <= slot_in;
            end
          end
        end
        ST_ERASE: begin
          if (hold_unused) begin
            state       <= ST_IDLE;
            prog_active <= 1'b0;
            prog_col    <= '0;
            prog_wl     <= '0;
            prog_bus    <= '0;
            prog_slot   <= '0;
            done        <= 1'b1;
          end else begin
            state    <= ST_ALLOC;
            prog_wl  <= hold_sec;
            prog_bus <= hold_bit;
          end
        end
        ST_ALLOC: begin
          state       <= ST_IDLE;
          prog_active <= 1'b0;
          prog_col    <= '0;
          prog_wl     <= '0;
          prog_bus    <= '0;
          prog_slot   <= '0;
          done        <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  erase_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_active && prog_wl == '1) |-> (prog_bus == '0));

  // R3
  alloc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_active && prog_bus != '0) |-> ($onehot(prog_wl) && $onehot(prog_bus)));

  // R3
  alloc_after_erase_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_active && prog_bus != '0) |-> $past(prog_active && prog_bus == '0 && prog_wl == '1));

  // R7
  col_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_active |-> (prog_col == '0 && prog_wl == '0));

  // R7
  col_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    prog_active |-> $onehot(prog_col));

  // R5
  done_after_prog_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(prog_active) && !prog_active && req_ready));

  // R9
  slot_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_active && $past(prog_active)) |-> $stable(prog_slot));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!prog_active && prog_wl == '0 && !done && req_ready));
endmodule

// File: rtl/xbar_prog_seq.sv
module xbar_prog_seq #(
  parameter int NUM_IN    = 128,
  parameter int BUS_W     = 16,
  parameter int NUM_OUT   = 16,
  parameter int NUM_SLOTS = 6,
  localparam int NUM_SEC  = NUM_IN / BUS_W,
  localparam int SRC_W    = $clog2(NUM_IN) + 1,
  localparam int CH_W     = $clog2(NUM_OUT),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CH_W-1:0]    req_chan,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [SLOT_W-1:0]  req_slot,
  input  logic               req_unused,
  output logic               prog_active,
  output logic [NUM_OUT-1:0] prog_col,
  output logic [NUM_SEC-1:0] prog_wl,
  output logic [BUS_W-1:0]   prog_bus,
  output logic [SLOT_W-1:0]  prog_slot,
  output logic               done,
  output logic               err
);
  logic [NUM_SEC-1:0] sec_oh;
  logic [BUS_W-1:0]   bit_oh;
  logic [NUM_OUT-1:0] col_oh;
  logic               req_ok;

  xbp_src_decode #(
    .NUM_IN(NUM_IN), .BUS_W(BUS_W), .NUM_SLOTS(NUM_SLOTS),
    .SRC_W(SRC_W), .SLOT_W(SLOT_W)
  ) u_src_dec (
    .src(req_src), .slot(req_slot), .unused(req_unused),
    .sec_oh(sec_oh), .bit_oh(bit_oh), .req_ok(req_ok)
  );

  xbp_col_decode #(.NUM_OUT(NUM_OUT), .CH_W(CH_W)) u_col_dec (
    .chan(req_chan), .col_oh(col_oh)
  );

  xbp_seq #(
    .NUM_SEC(NUM_SEC), .BUS_W(BUS_W), .NUM_OUT(NUM_OUT), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_unused(req_unused),
    .req_ok(req_ok), .sec_oh(sec_oh), .bit_oh(bit_oh), .col_oh(col_oh),
    .slot_in(req_slot), .req_ready(req_ready), .prog_active(prog_active),
    .prog_col(prog_col), .prog_wl(prog_wl), .prog_bus(prog_bus),
    .prog_slot(prog_slot), .done(done), .err(err)
  );

  // R2
  accept_erase_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_ok) |=> (prog_active && prog_wl == '1 && prog_bus == '0));

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    prog_active |-> !req_ready);

  // R6
  refuse_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_ok) |=> (err && !prog_active));
endmodule

// File: tb/xbar_prog_seq_tb.sv
`timescale 1ns/1ps
module xbar_prog_seq_tb;
  localparam int NI = 128;
  localparam int BW = 16;
  localparam int NO = 16;
  localparam int NS = NI / BW;
  localparam int SRCW = $clog2(NI) + 1;
  localparam int CHW = $clog2(NO);
  localparam int SLW = 3;

  typedef struct {
    bit            act;
    bit            dn;
    bit            er;
    logic [NS-1:0] wl;
    logic [BW-1:0] bus;
    logic [NO-1:0] col;
    logic [SLW-1:0] slot;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CHW-1:0] req_chan = '0;
  logic [SRCW-1:0] req_src = '0;
  logic [SLW-1:0] req_slot = '0;
  logic req_unused = 1'b0;
  logic prog_active;
  logic [NO-1:0] prog_col;
  logic [NS-1:0] prog_wl;
  logic [BW-1:0] prog_bus;
  logic [SLW-1:0] prog_slot;
  logic done, err;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  xbar_prog_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_src(req_src), .req_slot(req_slot),
    .req_unused(req_unused), .prog_active(prog_active), .prog_col(prog_col),
    .prog_wl(prog_wl), .prog_bus(prog_bus), .prog_slot(prog_slot),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(bit a, bit d, bit e, logic [NS-1:0] w,
                              logic [BW-1:0] b, logic [NO-1:0] c,
                              logic [SLW-1:0] s, string t);
    exp_t x;
    x.act = a; x.dn = d; x.er = e; x.wl = w; x.bus = b; x.col = c;
    x.slot = s; x.tag = t;
    return x;
  endfunction

  // Monitor: every cycle with activity pops one expected record.
  always @(negedge clk) begin
    if (!rst && (prog_active || done || err)) begin
      if (q.size() == 0) begin
        check(1'b0, "R1", "unexpected activity", 64'(prog_col), 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(prog_active == e.act && done == e.dn && err == e.er, e.tag,
              "act/done/err", {61'd0, prog_active, done, err},
              {61'd0, e.act, e.dn, e.er});
        check(prog_wl == e.wl, e.tag, "wordlines", 64'(prog_wl), 64'(e.wl));
        check(prog_bus == e.bus, e.tag, "bus code", 64'(prog_bus), 64'(e.bus));
        check(prog_col == e.col, e.tag, "column", 64'(prog_col), 64'(e.col));
        check(prog_slot == e.slot, e.tag, "slot", 64'(prog_slot), 64'(e.slot));
      end
    end
  end

  // Driver: presents one request and pushes the expected cycle records.
  task automatic send(input int ch, input int src, input int slot,
                      input bit unused, input bit hold_busy);
    bit good;
    logic [NO-1:0] col;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_chan = CHW'(ch);
    req_src = SRCW'(src);
    req_slot = SLW'(slot);
    req_unused = unused;
    req_valid = 1'b1;
    good = (slot < 6) && (unused || src < NI);
    col = NO'(1) << ch;
    if (!good) begin
      q.push_back(mk(1'b0, 1'b0, 1'b1, '0, '0, '0, '0, "R6"));
    end else begin
      q.push_back(mk(1'b1, 1'b0, 1'b0, '1, '0, col, SLW'(slot), "R2"));
      if (!unused)
        q.push_back(mk(1'b1, 1'b0, 1'b0, NS'(1) << (src / BW),
                       BW'(1) << (src % BW), col, SLW'(slot), "R3"));
      q.push_back(mk(1'b0, 1'b1, 1'b0, '0, '0, '0, '0, "R5"));
    end
    @(negedge clk);
    if (good && hold_busy) begin
      // R1: keep valid high with a different payload while busy
      req_chan = CHW'(9);
      req_src = SRCW'(1);
      check(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (good && !hold_busy)
      check(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
    if (!good)
      check(req_ready == 1'b1, "R6", "ready after refusal", 64'(req_ready), 64'd1);
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R5", "pending expected cycles", 64'(q.size()), 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(req_ready == 1'b1, "R8", "ready", 64'(req_ready), 64'd1);
    check(!prog_active && prog_col == '0 && prog_wl == '0 && prog_bus == '0 &&
          prog_slot == '0 && !done && !err, "R8", "outputs idle",
          64'(prog_col), 64'd0);

    send(5, 43, 2, 1'b0, 1'b0);    // R3 worked example: wl bit 2, bus bit 11
    drain();
    send(0, 0, 0, 1'b0, 1'b0);     // R3 first source, first column
    drain();
    send(15, 127, 5, 1'b0, 1'b0);  // R3 last source, last column, last slot
    drain();
    send(3, 0, 1, 1'b1, 1'b0);     // R4 unused column: erase only
    drain();
    send(4, 128, 1, 1'b0, 1'b0);   // R6 source just out of range
    drain();
    send(4, 255, 1, 1'b0, 1'b0);   // R6 source far out of range
    drain();
    send(4, 10, 6, 1'b0, 1'b0);    // R6 slot out of range
    drain();
    send(4, 10, 7, 1'b1, 1'b0);    // R6 bad slot even when unused
    drain();
    send(7, 200, 3, 1'b1, 1'b0);   // R4 source ignored when unused
    drain();
    send(12, 77, 4, 1'b0, 1'b1);   // R1 valid held while busy is ignored
    drain();
    // R9 back-to-back requests on different slots, R7 columns follow
    send(1, 16, 0, 1'b0, 1'b0);
    send(2, 31, 3, 1'b0, 1'b0);
    send(9, 64, 5, 1'b1, 1'b0);
    send(10, 95, 1, 1'b0, 1'b0);
    drain();
    // R7 no column enabled while idle
    check(prog_col == '0 && !prog_active, "R7", "idle column",
          64'(prog_col), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule